// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Binary Counter

This block is one stage of a binary up-counter, four bits wide by default. Every state change happens on the rising clock edge. There is no asynchronous path into the count register. Three active-low or active-high controls select what the stage does at each edge. A zeroing request wins over everything else. A preset request, which copies a parallel data word into the count, wins over counting. When neither is asserted, the stage advances by one only while both of its enables are high. Otherwise it keeps its value.

The stage drives a ripple-carry output. It is high only when the chain enable is high and the count is all ones. The local count enable has no influence on it. To build a wider counter, several stages share the clock, the zeroing and preset controls and the local count enable. Each stage's carry feeds the chain enable of the stage above it. The chain then steps as one wide binary counter, with the carry look-ahead supplied by the chain-enable path.

Top module: `bin_cnt_stage`

## Requirements
- R1: While sync_zero_n is low at a rising edge, cnt becomes all zeros after that edge, whatever preset_n, cnt_en, chain_en and din are.
- R2: While sync_zero_n is high and preset_n is low at a rising edge, cnt takes the value of din after that edge, whatever cnt_en and chain_en are.
- R3: While sync_zero_n and preset_n are both high and cnt_en and chain_en are both high at a rising edge, cnt becomes its previous value plus one.
- R4: While sync_zero_n and preset_n are both high and cnt_en or chain_en is low at a rising edge, cnt keeps its value.
- R5: An enabled count step from the all-ones value gives all zeros.
- R6: carry_out is 1 exactly when chain_en is 1 and every bit of cnt is 1. Otherwise it is 0.
- R7: carry_out is a combinational function of chain_en and cnt only. Changing cnt_en never changes it.
- R8: cnt changes only at a rising clock edge. Input changes between edges leave it unchanged.
- R9: When N stages share clk, sync_zero_n, preset_n and cnt_en, and each stage's carry_out drives the next stage's chain_en, the concatenated counts behave as one N*WIDTH-bit counter under R1 to R5. No value is skipped or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state changes occur on its rising edge |
| sync_zero_n | input | 1 | Active-low synchronous zeroing. It has the highest priority |
| preset_n | input | 1 | Active-low synchronous parallel load of din |
| cnt_en | input | 1 | Local count enable. It does not affect carry_out |
| chain_en | input | 1 | Chain count enable. It also gates carry_out |
| din | input | WIDTH | Parallel data loaded when preset_n is low |
| cnt | output | WIDTH | Current count |
| carry_out | output | 1 | High when chain_en is high and cnt is all ones |

## Verification
A corrupted count register shows on cnt immediately after the edge that wrote it. The bench compares every cycle against a 12-bit model, so a wrong next value is caught within one clock. A fault in the carry path does not show on the stage's own count. It shows on the next stage, which skips or misses a step at the first all-ones boundary. It also shows directly on carry_out, which the bench samples between edges. Wrap-around and look-ahead errors need the low stages to pass through all ones. Directed presets place the chained count just below those boundaries so that such errors appear within a few cycles.

// File: rtl/cnt_stage_pkg.sv
package cnt_stage_pkg;

    typedef enum logic [1:0] {
        MODE_ZERO   = 2'd0,
        MODE_PRESET = 2'd1,
        MODE_STEP   = 2'd2,
        MODE_KEEP   = 2'd3
    } stage_mode_e;

endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
    import cnt_stage_pkg::*;
(
    input  logic        sync_zero_n,
    input  logic        preset_n,
    input  logic        cnt_en,
    input  logic        chain_en,
    output stage_mode_e mode
);

    // Fixed priority: zero, preset, step, keep
    always_comb begin
        if (!sync_zero_n) begin
            mode = MODE_ZERO;
        end else if (!preset_n) begin
            mode = MODE_PRESET;
        end else if (cnt_en && chain_en) begin
            mode = MODE_STEP;
        end else begin
            mode = MODE_KEEP;
        end
    end

endmodule

// File: rtl/cnt_incr.sv
module cnt_incr #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);

    // Toggle chain: bit i flips when all lower bits are ones
    logic [WIDTH-1:0] flip;

    assign flip[0] = 1'b1;

    for (genvar i = 1; i < WIDTH; i++) begin : g_flip
        assign flip[i] = flip[i-1] & cur[i-1];
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign nxt[i] = cur[i] ^ flip[i];
    end

endmodule

// File: rtl/cnt_carry.sv
module cnt_carry #(
    parameter int WIDTH = 4
) (
    input  logic             chain_en,
    input  logic [WIDTH-1:0] cur,
    output logic             carry
);

    logic [WIDTH:0] ones;

    assign ones[0] = chain_en;

    for (genvar i = 0; i < WIDTH; i++) begin : g_and
        assign ones[i+1] = ones[i] & cur[i];
    end

    assign carry = ones[WIDTH];

endmodule

// File: rtl/bin_cnt_stage.sv
module bin_cnt_stage
    import cnt_stage_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             sync_zero_n,
    input  logic             preset_n,
    input  logic             cnt_en,
    input  logic             chain_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cnt,
    output logic             carry_out
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } stage_state_t;

    stage_state_t state_d;
    stage_state_t state_q;
    stage_mode_e  mode;
    logic [WIDTH-1:0] step_val;

    cnt_mode_dec u_mode_dec (
        .sync_zero_n (sync_zero_n),
        .preset_n    (preset_n),
        .cnt_en      (cnt_en),
        .chain_en    (chain_en),
        .mode        (mode)
    );

    cnt_incr #(.WIDTH(WIDTH)) u_incr (
        .cur (state_q.count),
        .nxt (step_val)
    );

    always_comb begin
        state_d = state_q;
        case (mode)
            MODE_ZERO:   state_d.count = '0;
            MODE_PRESET: state_d.count = din;
            MODE_STEP:   state_d.count = step_val;
            default:     state_d.count = state_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign cnt = state_q.count;

    cnt_carry #(.WIDTH(WIDTH)) u_carry (
        .chain_en (chain_en),
        .cur      (state_q.count),
        .carry    (carry_out)
    );

    AST_ZERO_WINS: assert property (@(posedge clk) !sync_zero_n |=> cnt == '0); // R1

    AST_PRESET_LOADS: assert property (@(posedge clk) disable iff (!sync_zero_n)
        (sync_zero_n && !preset_n) |=> cnt == $past(din)); // R2

    AST_STEP_ADDS_ONE: assert property (@(posedge clk) disable iff (!sync_zero_n)
        (sync_zero_n && preset_n && cnt_en && chain_en) |=> cnt == $past(cnt) + ONE); // R3

    AST_KEEP_HOLDS: assert property (@(posedge clk) disable iff (!sync_zero_n)
        (sync_zero_n && preset_n && !(cnt_en && chain_en)) |=> $stable(cnt)); // R4

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!sync_zero_n)
        (sync_zero_n && preset_n && cnt_en && chain_en && cnt == ALL_ONES) |=> cnt == '0); // R5

    AST_CARRY_NEEDS_CHAIN: assert property (@(posedge clk) !chain_en |-> !carry_out); // R6

    AST_CARRY_NEEDS_ONES: assert property (@(posedge clk) carry_out |-> cnt == ALL_ONES); // R6

    AST_CARRY_IGNORES_EN: assert property (@(posedge clk)
        (chain_en && cnt == ALL_ONES && !cnt_en) |-> carry_out); // R7

endmodule

// File: tb/bin_cnt_stage_bench.sv
module bin_cnt_stage_bench;

    localparam int W  = 4;
    localparam int NW = 3 * W;

    logic          clk = 1'b0;
    logic          sync_zero_n;
    logic          preset_n;
    logic          cnt_en;
    logic          chain_en;
    logic [NW-1:0] din;
    logic [W-1:0]  c0, c1, c2;
    logic          k0, k1, k2;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 0;
    bit known    = 0;
    logic [NW-1:0] model = '0;

    always #5 clk = ~clk;

    bin_cnt_stage #(.WIDTH(W)) u_bin_cnt_stage (
        .clk(clk), .sync_zero_n(sync_zero_n), .preset_n(preset_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .din(din[W-1:0]), .cnt(c0), .carry_out(k0));

    bin_cnt_stage #(.WIDTH(W)) u_bin_cnt_stage_mid (
        .clk(clk), .sync_zero_n(sync_zero_n), .preset_n(preset_n), .cnt_en(cnt_en),
        .chain_en(k0), .din(din[2*W-1:W]), .cnt(c1), .carry_out(k1));

    bin_cnt_stage #(.WIDTH(W)) u_bin_cnt_stage_hi (
        .clk(clk), .sync_zero_n(sync_zero_n), .preset_n(preset_n), .cnt_en(cnt_en),
        .chain_en(k1), .din(din[NW-1:2*W]), .cnt(c2), .carry_out(k2));

    wire [NW-1:0] full = {c2, c1, c0};

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NW-1:0] next_model(input logic z, input logic p, input logic e,
                                                 input logic t, input logic [NW-1:0] cur,
                                                 input logic [NW-1:0] d);
        if (!z)           return '0;
        else if (!p)      return d;
        else if (e && t)  return cur + NW'(1);
        else              return cur;
    endfunction

    function automatic string tag_of(input logic z, input logic p, input logic e,
                                     input logic t, input logic [NW-1:0] cur);
        if (!z)          return "R1";
        else if (!p)     return "R2";
        else if (e && t) return (cur[W-1:0] == '1) ? "R5" : "R3";
        else             return "R4";
    endfunction

    task automatic step(input logic z, input logic p, input logic e, input logic t,
                        input logic [NW-1:0] d);
        logic [NW-1:0] exp;
        logic x0, x1, x2;
        @(negedge clk);
        sync_zero_n = z; preset_n = p; cnt_en = e; chain_en = t; din = d;
        #1;
        if (known) begin
            chk(full == model, "R8", "count between edges", int'(full), int'(model));
            x0 = t && (model[W-1:0] == '1);
            x1 = x0 && (model[2*W-1:W] == '1);
            x2 = x1 && (model[NW-1:2*W] == '1);
            chk(k0 == x0, e ? "R6" : "R7", "stage0 carry", int'(k0), int'(x0));
            chk(k1 == x1, "R9", "stage1 carry", int'(k1), int'(x1));
            chk(k2 == x2, "R9", "stage2 carry", int'(k2), int'(x2));
        end
        exp = next_model(z, p, e, t, model, d);
        @(posedge clk);
        #1;
        if (known || !z) begin
            chk(full == exp, tag_of(z, p, e, t, model), "count after edge", int'(full), int'(exp));
            if (z && p && e && t)
                chk(full == exp, "R9", "chained step", int'(full), int'(exp));
        end
        model = exp;
        if (!z) known = 1;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        sync_zero_n = 1'b0; preset_n = 1'b0; cnt_en = 1'b0; chain_en = 1'b0; din = '0;
        // reset state via zeroing, R1
        step(0, 1, 1, 1, 12'h000);
        step(0, 0, 1, 1, 12'hABC);   // zero during preset, R1
        // preset then count, R2 and R3
        step(1, 0, 1, 1, 12'h3A7);
        step(1, 1, 1, 1, 12'h000);
        step(1, 0, 1, 1, 12'h123);   // preset during count, R2
        // hold via each enable, R4
        step(1, 1, 0, 1, 12'h000);
        step(1, 1, 1, 0, 12'h000);
        // wrap through stage boundaries, R5 and R9
        step(1, 0, 1, 1, 12'h0FD);
        for (int i = 0; i < 5; i++) step(1, 1, 1, 1, 12'h000);
        step(1, 0, 1, 1, 12'hFFD);
        for (int i = 0; i < 2; i++) step(1, 1, 1, 1, 12'h000);
        // at all ones: local enable low keeps carry, R7
        step(1, 1, 0, 1, 12'h000);
        step(1, 1, 0, 0, 12'h000);
        step(1, 1, 1, 1, 12'h000);
        step(1, 1, 1, 1, 12'h000);
        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom % 32;
            logic [NW-1:0] d = ($urandom % 2) ? NW'($urandom) : {8'hFF, 4'($urandom)};
            step(r != 0, r > 2, ($urandom % 8) != 0, ($urandom % 8) != 0, d);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule